// File: doc/BRIEF.md
# SMBus Packet Error Code Generator

This block forms the 8-bit packet error code of an SMBus transaction while its bytes go by. The bus controller around it presents each byte that crosses the wire on `byte_in` with a one-cycle `byte_vld` strobe. That includes the write address, the command code, the read address sent after a repeated start, and every data byte. Bit-level bus events never reach the block: start and stop conditions and acknowledge bits are left out. A 16-bit word goes in low byte first. A `clr` pulse at the start of a transaction returns the code to its starting value.

The running code is always visible on `crc_out`. When the controller receives a PEC byte, it strobes that byte with `chk` set. The byte is then compared with the running code rather than folded into it, and the result is held on `pec_ok`. For master-mode broadcasts, the controller names the destinations on `dest_sel`, and `pec_append` reports whether a PEC byte must be sent. Each destination has its own enable bit.

Top module: `smbus_pec_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `crc_out`, `pec_ok` and `pec_append` all become 0 after that edge.
- R2: A strobe with `chk`=0 and `clr`=0 updates the code with polynomial x^8+x^2+x+1 (0x07). The byte is XORed into the code, bits are shifted MSB first, and no final XOR is applied. The new value appears on `crc_out` after the strobing clock edge.
- R3: The bytes 0x16, 0x0F, 0x17, 0xE9, 0x03, fed after a clear, leave `crc_out` at 0xE8. This is the word 0x03E9 entered low byte first after two address bytes and a command byte.
- R4: `clr` without a strobe sets `crc_out` to 0x00 after the edge.
- R5: `clr` together with a data strobe (`chk`=0) gives the code of that byte alone, computed from 0x00.
- R6: In a cycle with neither strobe nor `clr`, `crc_out` keeps its value.
- R7: A strobe with `chk`=1 leaves `crc_out` unchanged. After the edge, `pec_ok` is 1 exactly when the byte equals the code in effect at that edge, which is 0x00 if `clr` is also high.
- R8: `clr` without a check strobe drives `pec_ok` to 0. With neither `clr` nor a check strobe, `pec_ok` holds its value.
- R9: `dest_sel` bit 0 names the charger and bit 1 names the host, and `dest_en` uses the same bit order. One cycle later, `pec_append` is 1 when at least one named destination has its enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Restart the code for a new transaction |
| byte_vld | input | 1 | Byte strobe |
| chk | input | 1 | With `byte_vld`: the byte is a received PEC to compare |
| byte_in | input | 8 | Transferred byte |
| dest_sel | input | 2 | Broadcast destinations: bit 0 charger, bit 1 host |
| dest_en | input | 2 | PEC enable per destination, same bit order |
| crc_out | output | 8 | Running packet error code |
| pec_ok | output | 1 | Result of the last PEC comparison |
| pec_append | output | 1 | Broadcast must carry a PEC byte |

## Verification
The update is tried on the five-byte read-word sequence with its known code. It is also tried on all-ones, all-zero, alternating and single-bit bytes, so that a wrong polynomial tap, a wrong shift direction or a missing XOR of the input is caught. Clearing is tried alone and together with a strobe, to tell "clear wins and the byte starts a new code" apart from "the byte is lost" or "the old code carries on". Check strobes are given with both matching and mismatching bytes, and once in the same cycle as a clear. Every combination of destination and enable is applied to the append decision.

// File: rtl/smbus_pec_pkg.sv
package smbus_pec_pkg;
  localparam int CRC_W = 8;

  function automatic logic [CRC_W-1:0] crc_step(
    input logic [CRC_W-1:0] cur,
    input logic [CRC_W-1:0] din,
    input logic [CRC_W-1:0] poly
  );
    logic [CRC_W-1:0] r;
    r = cur ^ din;
    for (int i = 0; i < CRC_W; i++) begin
      if (r[CRC_W-1]) r = (r << 1) ^ poly;
      else            r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/pec_crc_core.sv
module pec_crc_core
  import smbus_pec_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 8'h07,
  parameter logic [CRC_W-1:0] INIT = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic [CRC_W-1:0] din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] base;
  assign base = clr ? INIT : crc;

  always_ff @(posedge clk) begin
    if (rst)      crc <= INIT;
    else if (upd) crc <= crc_step(base, din, POLY);
    else if (clr) crc <= INIT;
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!upd && !clr) |=> $stable(crc));
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr && !upd) |=> (crc == INIT));
endmodule

// File: rtl/pec_compare.sv
module pec_compare
  import smbus_pec_pkg::*;
#(
  parameter logic [CRC_W-1:0] INIT = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             chk_vld,
  input  logic [CRC_W-1:0] din,
  input  logic [CRC_W-1:0] crc,
  output logic             pec_ok
);
  logic [CRC_W-1:0] ref_code;
  assign ref_code = clr ? INIT : crc;

  always_ff @(posedge clk) begin
    if (rst)          pec_ok <= 1'b0;
    else if (chk_vld) pec_ok <= (din == ref_code);
    else if (clr)     pec_ok <= 1'b0;
  end

  assert_ok_clr_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !chk_vld) |=> !pec_ok);
  assert_ok_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && !chk_vld) |=> $stable(pec_ok));
endmodule

// File: rtl/pec_append_ctl.sv
module pec_append_ctl #(
  parameter int NUM_DEST = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_DEST-1:0] dest_sel,
  input  logic [NUM_DEST-1:0] dest_en,
  output logic                pec_append
);
  logic [NUM_DEST-1:0] hit;

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_dest
    assign hit[g] = dest_sel[g] & dest_en[g];
  end

  always_ff @(posedge clk) begin
    if (rst) pec_append <= 1'b0;
    else     pec_append <= |hit;
  end

  assert_no_en_R9: assert property (@(posedge clk) disable iff (rst)
    (dest_en == '0) |=> !pec_append);
  assert_no_dest_R9: assert property (@(posedge clk) disable iff (rst)
    (dest_sel == '0) |=> !pec_append);
endmodule

// File: rtl/smbus_pec_gen.sv
module smbus_pec_gen
  import smbus_pec_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY     = 8'h07,
  parameter logic [CRC_W-1:0] INIT     = 8'h00,
  parameter int               NUM_DEST = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                byte_vld,
  input  logic                chk,
  input  logic [CRC_W-1:0]    byte_in,
  input  logic [NUM_DEST-1:0] dest_sel,
  input  logic [NUM_DEST-1:0] dest_en,
  output logic [CRC_W-1:0]    crc_out,
  output logic                pec_ok,
  output logic                pec_append
);
  logic upd;
  logic chk_vld;
  assign upd     = byte_vld & ~chk;
  assign chk_vld = byte_vld &  chk;

  pec_crc_core #(.POLY(POLY), .INIT(INIT)) u_core (
    .clk(clk), .rst(rst), .clr(clr), .upd(upd), .din(byte_in), .crc(crc_out)
  );

  pec_compare #(.INIT(INIT)) u_cmp (
    .clk(clk), .rst(rst), .clr(clr), .chk_vld(chk_vld),
    .din(byte_in), .crc(crc_out), .pec_ok(pec_ok)
  );

  pec_append_ctl #(.NUM_DEST(NUM_DEST)) u_app (
    .clk(clk), .rst(rst), .dest_sel(dest_sel), .dest_en(dest_en),
    .pec_append(pec_append)
  );

  assert_chk_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (chk_vld && !clr) |=> $stable(crc_out));
  assert_chk_clr_R7: assert property (@(posedge clk) disable iff (rst)
    (chk_vld && clr) |=> (crc_out == INIT));
endmodule

// File: tb/smbus_pec_gen_bench.sv
module smbus_pec_gen_bench;
  localparam int CLK_P = 10;
  localparam int NV = 12;
  // entry: {clr, byte}
  localparam logic [8:0] VEC [0:NV-1] = '{
    {1'b1, 8'h16}, {1'b0, 8'h0F}, {1'b0, 8'h17}, {1'b0, 8'hE9},
    {1'b0, 8'h03}, {1'b1, 8'hFF}, {1'b0, 8'h00}, {1'b0, 8'hAA},
    {1'b0, 8'h55}, {1'b0, 8'h80}, {1'b1, 8'h01}, {1'b0, 8'h7F}
  };

  logic clk = 0, rst = 1, clr = 0, byte_vld = 0, chk = 0;
  logic [7:0] byte_in = 0;
  logic [1:0] dest_sel = 0, dest_en = 0;
  logic [7:0] crc_out;
  logic pec_ok, pec_append;
  int errors = 0, checks = 0;
  logic [7:0] model = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  smbus_pec_gen u_smbus_pec_gen (
    .clk(clk), .rst(rst), .clr(clr), .byte_vld(byte_vld), .chk(chk),
    .byte_in(byte_in), .dest_sel(dest_sel), .dest_en(dest_en),
    .crc_out(crc_out), .pec_ok(pec_ok), .pec_append(pec_append)
  );

  function automatic logic [7:0] ref_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int b = 0; b < 8; b++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus driven at negedge; outputs sampled at next negedge
  task automatic cyc(input logic c, input logic v, input logic k, input logic [7:0] d);
    @(negedge clk);
    clr = c; byte_vld = v; chk = k; byte_in = d;
    @(negedge clk);
    clr = 0; byte_vld = 0; chk = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 crc", crc_out, 8'h00);
    check("R1 ok", {7'b0, pec_ok}, 8'h00);
    check("R1 append", {7'b0, pec_append}, 8'h00);

    // table walk: R2 updates, R5 clear-with-strobe entries
    for (int i = 0; i < NV; i++) begin
      model = ref_step(VEC[i][8] ? 8'h00 : model, VEC[i][7:0]);
      cyc(VEC[i][8], 1'b1, 1'b0, VEC[i][7:0]);
      check(VEC[i][8] ? "R5 clr+strobe" : "R2 update", crc_out, model);
    end

    // R3 known read-word vector
    cyc(1, 0, 0, 8'h00);
    cyc(0, 1, 0, 8'h16); cyc(0, 1, 0, 8'h0F); cyc(0, 1, 0, 8'h17);
    cyc(0, 1, 0, 8'hE9); cyc(0, 1, 0, 8'h03);
    check("R3 vector", crc_out, 8'hE8);

    // R6 idle holds
    repeat (3) @(negedge clk);
    check("R6 hold", crc_out, 8'hE8);

    // R7 matching check, crc unchanged
    cyc(0, 1, 1, 8'hE8);
    check("R7 match ok", {7'b0, pec_ok}, 8'h01);
    check("R7 crc kept", crc_out, 8'hE8);
    // R8 hold
    cyc(0, 0, 0, 8'h00);
    check("R8 ok hold", {7'b0, pec_ok}, 8'h01);
    // R7 mismatch
    cyc(0, 1, 1, 8'hE9);
    check("R7 mismatch", {7'b0, pec_ok}, 8'h00);
    cyc(0, 1, 1, 8'hE8);
    // R4/R8 clear
    cyc(1, 0, 0, 8'h00);
    check("R4 clear", crc_out, 8'h00);
    check("R8 ok cleared", {7'b0, pec_ok}, 8'h00);
    // R7 check with clear compares against 0x00
    cyc(0, 1, 0, 8'h01);
    check("R2 single", crc_out, 8'h07);
    cyc(1, 1, 1, 8'h00);
    check("R7 clr+chk ok", {7'b0, pec_ok}, 8'h01);
    check("R7 clr+chk crc", crc_out, 8'h00);

    // R9 all combinations
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        @(negedge clk);
        dest_sel = s[1:0]; dest_en = e[1:0];
        @(negedge clk);
        check("R9 append", {7'b0, pec_append}, {7'b0, |(s[1:0] & e[1:0])});
      end
    end

    // R1 reset mid-run
    cyc(0, 1, 0, 8'h5A);
    dest_sel = 2'b11; dest_en = 2'b11;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 crc again", crc_out, 8'h00);
    check("R1 append again", {7'b0, pec_append}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule